// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level page table held in memory. A client offers a request with a valid/ready handshake. The request carries the virtual address, a flag that marks a user-mode access and a flag that marks a write. The walker then issues up to two word reads through a simple memory read port. The first read fetches the directory entry and the second fetches the table entry. It checks each entry's permission flags and returns either the physical address or a fault with a cause code and the level that faulted.

Pages are 4 KiB. The top ten address bits index the directory and the next ten bits index the table. The low twelve bits pass through unchanged as the page offset. The directory base address and a supervisor write-protect enable are inputs, and both are sampled when a request is accepted. Only one walk is in flight at a time. The memory read port tolerates any read latency: the walker holds its read strobe and address until the memory signals valid data.

Top module: `page_walker`

## Requirements
- R1: After reset, reqReady is 1, memReadEn is 0, rspDone is 0 and rspFault is 0.
- R2: The first read of a walk is at rootBase + 4 × reqVaddr[31:22].
- R3: The second read is at (directory entry with bits 11:0 cleared) + 4 × reqVaddr[21:12].
- R4: A walk with no fault pulses rspDone for exactly one cycle with rspFault = 0, rspCause = 0, and rspPaddr = {table entry[31:12], reqVaddr[11:0]}.
- R5: Entry flag bit 0 is "present". If it is clear, the walk ends with rspCause = 1. rspLevel gives the level that faulted: 0 for the directory entry, 1 for the table entry.
- R6: Entry flag bit 2 is "user allowed". If it is clear and reqUser = 1, the walk ends with rspCause = 2.
- R7: Entry flag bit 1 is "writable". A user-mode write (reqUser = 1, reqWrite = 1) to an entry with this bit clear ends with rspCause = 3.
- R8: A supervisor write (reqUser = 0, reqWrite = 1) to an entry with bit 1 clear faults with rspCause = 3 only when wpEnable is 1. Otherwise it is allowed.
- R9: When the directory entry faults, no second read is issued. The result is reported after a single read.
- R10: reqReady is high only while the walker is idle. memReadEn stays high with a stable memAddr until memRdValid arrives, whatever the latency.
- R11: The checks on an entry apply in the order present, then user, then write. On any fault, rspPaddr is 0.
- R12: rootBase and wpEnable are captured when a request is accepted. Later changes to them do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request offered |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqUser | input | 1 | 1 = user-mode access, 0 = supervisor |
| reqWrite | input | 1 | 1 = write access |
| rootBase | input | 32 | Physical address of the directory |
| wpEnable | input | 1 | Supervisor writes honour read-only entries |
| memAddr | output | 32 | Word address of the entry being read |
| memReadEn | output | 1 | Read request, held until data returns |
| memRdValid | input | 1 | Read data valid this cycle |
| memRdData | input | 32 | Entry read from memory |
| rspDone | output | 1 | One-cycle pulse: the response fields are valid |
| rspFault | output | 1 | Walk ended in a fault |
| rspCause | output | 2 | 0 none, 1 not present, 2 user access, 3 write protect |
| rspLevel | output | 1 | Level that faulted: 0 directory, 1 table |
| rspPaddr | output | 32 | Translated physical address, 0 on fault |

## Verification
The bench goes after the permission corners. These are a supervisor write to a read-only page with write protect both on and off, a user write to a page that is both read-only and supervisor-only (which must report the user cause, not the write cause), and a page that is not present but has every other flag set. A walker with the checks in the wrong order, or one that ignores the protect enable, reports the wrong cause or translates when it should fault. A directory fault must stop after one read. A walker that fetches the table entry anyway is caught by the read count. The bench also changes the root pointer and the protect enable right after acceptance and varies the memory latency, which exposes a walker that uses live inputs or drops its read before data arrives.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READ_DIR = 2'd1,
    ST_READ_TBL = 2'd2,
    ST_DONE     = 2'd3
  } walkStateT;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_PRIV   = 2'd2,
    CAUSE_RDONLY = 2'd3
  } faultCauseT;

  typedef struct packed {
    logic capture;
    logic latchDir;
    logic respond;
    logic tableLevel;
  } walkStrobeT;

  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_USER    = 2;

  function automatic faultCauseT judgeEntry(input logic [2:0] flags,
                                            input logic isUser,
                                            input logic isWrite,
                                            input logic wpOn);
    faultCauseT res;
    res = CAUSE_NONE;
    if (!flags[FLAG_PRESENT])
      res = CAUSE_ABSENT;
    else if (isUser && !flags[FLAG_USER])
      res = CAUSE_PRIV;
    else if (isWrite && !flags[FLAG_WRITE] && (isUser || wpOn))
      res = CAUSE_RDONLY;
    return res;
  endfunction

endpackage

// File: rtl/page_walker_ctrl.sv
module page_walker_ctrl
  import page_walker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memRdValid,
  input  logic       entryFault,
  output logic       reqReady,
  output logic       memReadEn,
  output logic       rspDone,
  output walkStrobeT strobe
);

  walkStateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqReady  = 1'b0;
    memReadEn = 1'b0;
    rspDone   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState      = ST_READ_DIR;
        end
      end
      ST_READ_DIR: begin
        memReadEn = 1'b1;
        if (memRdValid) begin
          if (entryFault) begin
            strobe.respond = 1'b1;
            nextState      = ST_DONE;
          end else begin
            strobe.latchDir = 1'b1;
            nextState       = ST_READ_TBL;
          end
        end
      end
      ST_READ_TBL: begin
        memReadEn         = 1'b1;
        strobe.tableLevel = 1'b1;
        if (memRdValid) begin
          strobe.respond = 1'b1;
          nextState      = ST_DONE;
        end
      end
      ST_DONE: begin
        rspDone   = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/page_walker_dp.sv
module page_walker_dp
  import page_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int INDEX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobeT        strobe,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqUser,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] rootBase,
  input  logic              wpEnable,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              entryFault,
  output logic              rspFault,
  output logic [1:0]        rspCause,
  output logic              rspLevel,
  output logic [ADDR_W-1:0] rspPaddr
);

  localparam int FRAME_W = ADDR_W - OFFSET_W;
  localparam int IDX_B_W = INDEX_W + 2;

  logic [ADDR_W-1:0]  vaReg, rootReg;
  logic               userReg, writeReg, wpReg;
  logic [FRAME_W-1:0] dirFrameReg;
  faultCauseT         entryCause;
  logic [ADDR_W-1:0]  dirAddr, tblAddr;
  logic               unusedFlagBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      rootReg  <= '0;
      userReg  <= 1'b0;
      writeReg <= 1'b0;
      wpReg    <= 1'b0;
    end else if (strobe.capture) begin
      vaReg    <= reqVaddr;
      rootReg  <= rootBase;
      userReg  <= reqUser;
      writeReg <= reqWrite;
      wpReg    <= wpEnable;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dirFrameReg <= '0;
    else if (strobe.latchDir) dirFrameReg <= memRdData[ADDR_W-1:OFFSET_W];
  end

  assign dirAddr = rootReg +
                   ADDR_W'({vaReg[ADDR_W-1 -: INDEX_W], 2'b00});
  assign tblAddr = {dirFrameReg, {OFFSET_W{1'b0}}} +
                   ADDR_W'({vaReg[OFFSET_W +: INDEX_W], 2'b00});
  assign memAddr = strobe.tableLevel ? tblAddr : dirAddr;

  assign entryCause     = judgeEntry(memRdData[2:0], userReg, writeReg, wpReg);
  assign entryFault     = (entryCause != CAUSE_NONE);
  assign unusedFlagBits = ^{memRdData[OFFSET_W-1:3], IDX_B_W[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspFault <= 1'b0;
      rspCause <= CAUSE_NONE;
      rspLevel <= 1'b0;
      rspPaddr <= '0;
    end else if (strobe.respond) begin
      rspFault <= entryFault;
      rspCause <= entryCause;
      rspLevel <= strobe.tableLevel;
      rspPaddr <= entryFault ? '0
                             : {memRdData[ADDR_W-1:OFFSET_W], vaReg[OFFSET_W-1:0]};
    end
  end

endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int INDEX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqUser,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] rootBase,
  input  logic              wpEnable,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memReadEn,
  input  logic              memRdValid,
  input  logic [ADDR_W-1:0] memRdData,
  output logic              rspDone,
  output logic              rspFault,
  output logic [1:0]        rspCause,
  output logic              rspLevel,
  output logic [ADDR_W-1:0] rspPaddr
);

  walkStrobeT strobe;
  logic       entryFault;

  page_walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRdValid (memRdValid),
    .entryFault (entryFault),
    .reqReady   (reqReady),
    .memReadEn  (memReadEn),
    .rspDone    (rspDone),
    .strobe     (strobe)
  );

  page_walker_dp #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .INDEX_W  (INDEX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqUser    (reqUser),
    .reqWrite   (reqWrite),
    .rootBase   (rootBase),
    .wpEnable   (wpEnable),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .entryFault (entryFault),
    .rspFault   (rspFault),
    .rspCause   (rspCause),
    .rspLevel   (rspLevel),
    .rspPaddr   (rspPaddr)
  );

endmodule

// File: rtl/page_walker_checker.sv
module page_walker_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memReadEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              rspDone,
  input logic              rspFault,
  input logic [1:0]        rspCause,
  input logic [ADDR_W-1:0] rspPaddr
);

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReadEn); // R10

  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady && memReadEn); // R10

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReadEn && !memRdValid |=> memReadEn && $stable(memAddr)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R4

  AST_CLEAN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone && !rspFault |-> rspCause == 2'd0); // R4

  AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspDone && rspFault |-> rspPaddr == '0 && rspCause != 2'd0); // R11

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspDone) |-> $past(memReadEn && memRdValid)); // R9

endmodule

bind page_walker page_walker_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .memReadEn  (memReadEn),
  .memAddr    (memAddr),
  .memRdValid (memRdValid),
  .rspDone    (rspDone),
  .rspFault   (rspFault),
  .rspCause   (rspCause),
  .rspPaddr   (rspPaddr)
);

// File: tb/page_walker_test.sv
`timescale 1ns/1ps
module page_walker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqUser = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] rootBase = 32'h0010_0000;
  logic        wpEnable = 1'b0;
  logic [31:0] memAddr;
  logic        memReadEn;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        rspDone;
  logic        rspFault;
  logic [1:0]  rspCause;
  logic        rspLevel;
  logic [31:0] rspPaddr;

  int nChecks = 0;
  int nFails  = 0;
  int latency = 0;
  int waitCnt = 0;
  int readCount = 0;
  logic [31:0] rdAddr0, rdAddr1;
  logic        gotDone;
  logic [31:0] memMap [logic [31:0]];

  always #2 clk = ~clk;

  page_walker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqUser(reqUser), .reqWrite(reqWrite),
    .rootBase(rootBase), .wpEnable(wpEnable), .memAddr(memAddr),
    .memReadEn(memReadEn), .memRdValid(memRdValid), .memRdData(memRdData),
    .rspDone(rspDone), .rspFault(rspFault), .rspCause(rspCause),
    .rspLevel(rspLevel), .rspPaddr(rspPaddr)
  );

  function automatic logic [31:0] lookup(input logic [31:0] a);
    return memMap.exists(a) ? memMap[a] : 32'h0;
  endfunction

  // memory model: answers after 'latency' idle cycles
  always @(negedge clk) begin
    memRdValid <= 1'b0;
    if (memReadEn && !memRdValid) begin
      if (waitCnt >= latency) begin
        memRdValid <= 1'b1;
        memRdData  <= lookup(memAddr);
        if (readCount == 0) rdAddr0 = memAddr;
        else                rdAddr1 = memAddr;
        readCount = readCount + 1;
        waitCnt   = 0;
      end else waitCnt = waitCnt + 1;
    end else waitCnt = 0;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runWalk(input logic [31:0] va, input logic usr, input logic wr,
                         input logic wpAccept, input logic [31:0] rootAccept,
                         input logic wpAfter, input logic [31:0] rootAfter,
                         input int lat);
    latency = lat;
    readCount = 0;
    rdAddr0 = '0;
    rdAddr1 = '0;
    gotDone = 1'b0;
    @(negedge clk);
    reqVaddr = va; reqUser = usr; reqWrite = wr;
    wpEnable = wpAccept; rootBase = rootAccept; reqValid = 1'b1;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    wpEnable = wpAfter; rootBase = rootAfter;
    check("R10", "ready during walk", {31'b0, reqReady}, 32'd0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rspDone) begin gotDone = 1'b1; break; end
    end
    check("R10", "walk completes", {31'b0, gotDone}, 32'd1);
  endtask

  task automatic expectOk(input string tag, input logic [31:0] pa, input int reads);
    check(tag, "fault", {31'b0, rspFault}, 32'd0);
    check(tag, "cause", {30'b0, rspCause}, 32'd0);
    check(tag, "paddr", rspPaddr, pa);
    check(tag, "reads", readCount, reads);
  endtask

  task automatic expectFault(input string tag, input logic [1:0] cause,
                             input logic lvl, input int reads);
    check(tag, "fault", {31'b0, rspFault}, 32'd1);
    check(tag, "cause", {30'b0, rspCause}, {30'b0, cause});
    check(tag, "level", {31'b0, rspLevel}, {31'b0, lvl});
    check("R11", "paddr zero on fault", rspPaddr, 32'h0);
    check(tag, "reads", readCount, reads);
  endtask

  task automatic testReset();
    check("R1", "reqReady", {31'b0, reqReady}, 32'd1);
    check("R1", "memReadEn", {31'b0, memReadEn}, 32'd0);
    check("R1", "rspDone", {31'b0, rspDone}, 32'd0);
    check("R1", "rspFault", {31'b0, rspFault}, 32'd0);
  endtask

  task automatic testBasic();
    runWalk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 0);
    check("R2", "dir read addr", rdAddr0, 32'h0010_0004);
    check("R3", "tbl read addr", rdAddr1, 32'h0020_000C);
    expectOk("R4", 32'h1234_5ABC, 2);
    check("R4", "done pulse", {31'b0, rspDone}, 32'd1);
    @(negedge clk);
    check("R4", "done falls", {31'b0, rspDone}, 32'd0);
    check("R1", "ready again", {31'b0, reqReady}, 32'd1);
  endtask

  task automatic testLatency();
    runWalk(32'h0040_3FFF, 1'b1, 1'b1, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 5);
    check("R10", "tbl addr held", rdAddr1, 32'h0020_000C);
    expectOk("R10", 32'h1234_5FFF, 2);
    runWalk(32'h0040_3000, 1'b1, 1'b0, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 2);
    expectOk("R4", 32'h1234_5000, 2);
  endtask

  task automatic testNotPresent();
    runWalk(32'h0080_0000, 1'b0, 1'b0, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 1);
    expectFault("R5", 2'd1, 1'b0, 1);
    check("R9", "single read addr", rdAddr0, 32'h0010_0008);
    runWalk(32'h0040_4000, 1'b0, 1'b0, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 0);
    expectFault("R5", 2'd1, 1'b1, 2);
  endtask

  task automatic testUserAccess();
    runWalk(32'h00C0_0010, 1'b1, 1'b0, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 0);
    expectFault("R6", 2'd2, 1'b0, 1);
    runWalk(32'h00C0_0010, 1'b0, 1'b0, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 0);
    expectOk("R6", 32'h0ABC_D010, 2);
  endtask

  task automatic testUserWrite();
    runWalk(32'h0100_0000, 1'b1, 1'b1, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 0);
    expectFault("R7", 2'd3, 1'b0, 1);
    runWalk(32'h0100_0000, 1'b1, 1'b0, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 0);
    expectOk("R7", 32'h0CAF_E000, 2);
    runWalk(32'h0040_5123, 1'b1, 1'b1, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 3);
    expectFault("R7", 2'd3, 1'b1, 2);
  endtask

  task automatic testSupervisorWrite();
    runWalk(32'h0100_0000, 1'b0, 1'b1, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 0);
    expectOk("R8", 32'h0CAF_E000, 2);
    runWalk(32'h0100_0000, 1'b0, 1'b1, 1'b1, 32'h0010_0000, 1'b1, 32'h0010_0000, 0);
    expectFault("R8", 2'd3, 1'b0, 1);
  endtask

  task automatic testPriority();
    runWalk(32'h0140_0000, 1'b1, 1'b1, 1'b0, 32'h0010_0000, 1'b0, 32'h0010_0000, 0);
    expectFault("R11", 2'd2, 1'b0, 1);
    runWalk(32'h0180_0000, 1'b1, 1'b1, 1'b1, 32'h0010_0000, 1'b1, 32'h0010_0000, 0);
    expectFault("R11", 2'd1, 1'b0, 1);
  endtask

  task automatic testCapture();
    runWalk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0, 32'h0050_0000, 1'b0, 32'h0010_0000, 2);
    check("R12", "dir addr uses captured root", rdAddr0, 32'h0050_0004);
    expectOk("R12", 32'h0DDD_DABC, 2);
    runWalk(32'h0100_0000, 1'b0, 1'b1, 1'b1, 32'h0010_0000, 1'b0, 32'h0010_0000, 2);
    expectFault("R12", 2'd3, 1'b0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    memMap[32'h0010_0004] = 32'h0020_0007;
    memMap[32'h0010_000C] = 32'h0030_0003;
    memMap[32'h0010_0010] = 32'h0040_0005;
    memMap[32'h0010_0014] = 32'h0070_0001;
    memMap[32'h0010_0018] = 32'h0080_0006;
    memMap[32'h0020_000C] = 32'h1234_5007;
    memMap[32'h0020_0014] = 32'h0BEE_F005;
    memMap[32'h0030_0000] = 32'h0ABC_D003;
    memMap[32'h0040_0000] = 32'h0CAF_E005;
    memMap[32'h0050_0004] = 32'h0060_0007;
    memMap[32'h0060_000C] = 32'h0DDD_D007;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testBasic();
    testLatency();
    testNotPresent();
    testUserAccess();
    testUserWrite();
    testSupervisorWrite();
    testPriority();
    testCapture();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule